// File: doc/BRIEF.md
# Sectioned GPIO Controller with Latched Interrupts

The block controls 32 general-purpose pins arranged as four banks of eight. Pin number N belongs to bank N>>3 at bit N&7, so pin 10 is bit 2 of bank 1. Each bank has its own window of sixteen 16-bit word registers on a simple register bus. The window covers pin direction, output value, synchronised input value, raw and masked interrupt status, an interrupt mask, and a per-pin latch-mode setting. Only the low eight bits of each register are implemented.

Every pin produces an interrupt condition. By default the condition follows the synchronised pin level. In latched mode the condition is captured when the pin is seen high and stays set until software clears it. The mask is changed only through two write-1 ports: one sets mask bits and the other clears them. The masked conditions of all four banks are merged into one interrupt line.

A bus access is acknowledged one cycle after the request appears. Read data is presented during the acknowledge cycle. A write takes effect on the clock edge that ends the acknowledge cycle.

Top module: `gpio_sect_ctrl`

## Requirements
- R1: After reset every pin is an input, so the direction register reads 0x00FF and gpio_oe_o is 0. All outputs are 0, every mask bit is set (mask reads 0x00FF), latch mode is off everywhere (reads 0x0000) and irq_o is 0.
- R2: The word address is {bank[1:0], index[3:0]}, with register indices: 0 masked status, 1 raw status, 2 mask, 3 unmask, 4 direction, 5 output, 6 input, 8 latch mode. Bit b of bank k controls pin 8k+b. gpio_o carries the output register, and gpio_oe_o[n] is high when the direction bit is 0, because a direction bit of 1 means input.
- R3: The input register returns gpio_i after a two-flop synchroniser. A pin change reaches the interrupt logic on the second rising edge after it is applied.
- R4: For a pin not in latch mode, raw status bit = current synchronised pin level, rising and falling with the pin.
- R5: For a pin in latch mode, raw status becomes 1 once the pin is seen high and stays 1 after the pin falls. Writing 1 to that bit at index 1 clears it, and bits written as 0 have no effect. If the pin is still high during the clear, the bit stays set.
- R6: Writing index 2 sets the mask bits written as 1, and writing index 3 clears the mask bits written as 1. Bits written as 0 are unchanged, and index 3 reads as 0.
- R7: Masked status = raw status AND NOT mask. irq_o is the OR of all masked status bits of all four banks.
- R8: Writing index 8 enables latch mode for the bits written as 1. No bus write turns latch mode off.
- R9: Bits 15:8 of every register read 0 and ignore writes. Writes to index 0 and index 6 have no effect.
- R10: With req_valid_i high and req_ready_o low, req_ready_o is 1 in the next cycle and 0 in the cycle after, and req_rdata_o holds the read value while req_ready_o is 1. A write commits on the edge where req_valid_i and req_ready_o are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Bus request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 6 | Word address {bank, register index} |
| req_wdata_i | input | 16 | Write data |
| req_ready_o | output | 1 | Access acknowledge |
| req_rdata_o | output | 16 | Read data, valid while req_ready_o is high |
| gpio_i | input | 32 | Pin input levels |
| gpio_o | output | 32 | Pin output values |
| gpio_oe_o | output | 32 | Pin output enables, 1 = drive |
| irq_o | output | 1 | Merged interrupt request |

## Verification
Each result has a fixed latency from its stimulus:
- The bus acknowledge arrives one edge after the request.
- A write is visible in register state and on the pin outputs from the edge that ends the acknowledge cycle.
- A non-latched pin reaches raw status and irq_o on the second edge after the pin changes.
- A latched pin needs one more edge.

The bench drives inputs and samples outputs on falling edges. It checks the handshake and the non-latched interrupt path at exactly those edges, showing the result is absent one edge early and present on time. Slower paths are read back over the bus only after their latency has passed.

// File: rtl/gpio_sect_pkg.sv
package gpio_sect_pkg;
  localparam int unsigned REG_IDX_W = 4;

  typedef enum logic [REG_IDX_W-1:0] {
    RI_MSTAT  = 4'h0,
    RI_STAT   = 4'h1,
    RI_MASK   = 4'h2,
    RI_UNMASK = 4'h3,
    RI_DIR    = 4'h4,
    RI_OUT    = 4'h5,
    RI_IN     = 4'h6,
    RI_STICKY = 4'h8
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_reg_port.sv
module gpio_reg_port #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic              ready_o,
  output logic              wr_commit_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              ready_q;
  logic [DATA_W-1:0] rdata_q;

  // one wait state per access; read data captured with the acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= valid_i & ~ready_q;
      if (valid_i && !ready_q) rdata_q <= rd_word_i;
    end
  end

  assign ready_o     = ready_q;
  assign rdata_o     = rdata_q;
  assign wr_commit_o = valid_i & ready_q & write_i;
endmodule

// File: rtl/gpio_sect_bank.sv
module gpio_sect_bank
  import gpio_sect_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [REG_IDX_W-1:0] widx_i,
  input  logic [PINS-1:0]      wdata_i,
  input  logic [PINS-1:0]      pin_i,
  output logic [PINS-1:0]      dir_o,
  output logic [PINS-1:0]      out_o,
  output logic [PINS-1:0]      mask_o,
  output logic [PINS-1:0]      sticky_o,
  output logic [PINS-1:0]      raw_o,
  output logic [PINS-1:0]      mstat_o
);
  logic [PINS-1:0] dir_q, out_q, mask_q, sticky_q, latch_q;
  logic [PINS-1:0] clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q    <= '1;
      out_q    <= '0;
      mask_q   <= '1;
      sticky_q <= '0;
    end else if (wr_i) begin
      case (widx_i)
        RI_DIR:    dir_q    <= wdata_i;
        RI_OUT:    out_q    <= wdata_i;
        RI_MASK:   mask_q   <= mask_q | wdata_i;
        RI_UNMASK: mask_q   <= mask_q & ~wdata_i;
        RI_STICKY: sticky_q <= sticky_q | wdata_i;
        default: ;
      endcase
    end
  end

  assign clr = (wr_i && widx_i == RI_STAT) ? wdata_i : '0;

  // a pin seen high wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= '0;
    else         latch_q <= sticky_q & ((latch_q & ~clr) | pin_i);
  end

  for (genvar b = 0; b < PINS; b++) begin : g_pin
    assign raw_o[b] = sticky_q[b] ? latch_q[b] : pin_i[b];
  end

  assign mstat_o  = raw_o & ~mask_q;
  assign dir_o    = dir_q;
  assign out_o    = out_q;
  assign mask_o   = mask_q;
  assign sticky_o = sticky_q;
endmodule

// File: rtl/gpio_sect_ctrl.sv
module gpio_sect_ctrl
  import gpio_sect_pkg::*;
#(
  parameter int unsigned NUM_SECT  = 4,
  parameter int unsigned SECT_PINS = 8,
  parameter int unsigned DATA_W    = 16,
  localparam int unsigned NPINS    = NUM_SECT * SECT_PINS,
  localparam int unsigned SEL_W    = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1,
  localparam int unsigned ADDR_W   = SEL_W + REG_IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] req_rdata_o,
  input  logic [NPINS-1:0]  gpio_i,
  output logic [NPINS-1:0]  gpio_o,
  output logic [NPINS-1:0]  gpio_oe_o,
  output logic              irq_o
);
  logic [NPINS-1:0]     pin_s;
  logic [NPINS-1:0]     dir_all, out_all, mask_all, sticky_all, raw_all, mstat_all;
  logic                 wr_commit;
  logic [SEL_W-1:0]     sel;
  logic [REG_IDX_W-1:0] idx;
  logic [SECT_PINS-1:0] rd_byte;
  logic [DATA_W-1:0]    rd_word;
  logic                 unused_wdata_hi;

  assign sel = req_addr_i[ADDR_W-1 -: SEL_W];
  assign idx = req_addr_i[REG_IDX_W-1:0];
  assign unused_wdata_hi = ^req_wdata_i[DATA_W-1:SECT_PINS];

  gpio_sync2 #(.W(NPINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_i),
    .q_o   (pin_s)
  );

  gpio_reg_port #(.DATA_W(DATA_W)) u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (req_valid_i),
    .write_i    (req_write_i),
    .rd_word_i  (rd_word),
    .ready_o    (req_ready_o),
    .wr_commit_o(wr_commit),
    .rdata_o    (req_rdata_o)
  );

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    localparam int unsigned LO = s * SECT_PINS;
    logic bank_wr;
    assign bank_wr = wr_commit && (sel == SEL_W'(s));

    gpio_sect_bank #(.PINS(SECT_PINS)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (bank_wr),
      .widx_i  (idx),
      .wdata_i (req_wdata_i[SECT_PINS-1:0]),
      .pin_i   (pin_s[LO +: SECT_PINS]),
      .dir_o   (dir_all[LO +: SECT_PINS]),
      .out_o   (out_all[LO +: SECT_PINS]),
      .mask_o  (mask_all[LO +: SECT_PINS]),
      .sticky_o(sticky_all[LO +: SECT_PINS]),
      .raw_o   (raw_all[LO +: SECT_PINS]),
      .mstat_o (mstat_all[LO +: SECT_PINS])
    );
  end

  always_comb begin
    rd_byte = '0;
    for (int s = 0; s < NUM_SECT; s++) begin
      if (sel == SEL_W'(s)) begin
        case (idx)
          RI_MSTAT:  rd_byte = mstat_all[s*SECT_PINS +: SECT_PINS];
          RI_STAT:   rd_byte = raw_all[s*SECT_PINS +: SECT_PINS];
          RI_MASK:   rd_byte = mask_all[s*SECT_PINS +: SECT_PINS];
          RI_DIR:    rd_byte = dir_all[s*SECT_PINS +: SECT_PINS];
          RI_OUT:    rd_byte = out_all[s*SECT_PINS +: SECT_PINS];
          RI_IN:     rd_byte = pin_s[s*SECT_PINS +: SECT_PINS];
          RI_STICKY: rd_byte = sticky_all[s*SECT_PINS +: SECT_PINS];
          default:   rd_byte = '0;
        endcase
      end
    end
  end

  assign rd_word   = {{(DATA_W-SECT_PINS){1'b0}}, rd_byte};
  assign gpio_o    = out_all;
  assign gpio_oe_o = ~dir_all;
  assign irq_o     = |mstat_all;
endmodule

// File: rtl/gpio_sect_ctrl_chk.sv
module gpio_sect_ctrl_chk #(
  parameter int unsigned NPINS = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             irq_o,
  input logic [NPINS-1:0] gpio_oe_o,
  input logic [NPINS-1:0] mask_all,
  input logic [NPINS-1:0] sticky_all,
  input logic [NPINS-1:0] raw_all,
  input logic             wr_commit
);
  p_ready_follows_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ready_o) |=> req_ready_o);

  p_ready_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> !req_ready_o);

  p_ready_needs_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_ready_o) |-> $past(req_valid_i));

  p_irq_needs_unmask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_all != '1));

  p_oe_only_by_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_commit) |-> $stable(gpio_oe_o));

  p_sticky_never_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(sticky_all) & ~sticky_all) == '0));

  p_latch_clear_by_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(sticky_all & $past(sticky_all) & $past(raw_all) & ~raw_all)) |-> $past(wr_commit));
endmodule

bind gpio_sect_ctrl gpio_sect_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .irq_o      (irq_o),
  .gpio_oe_o  (gpio_oe_o),
  .mask_all   (mask_all),
  .sticky_all (sticky_all),
  .raw_all    (raw_all),
  .wr_commit  (wr_commit)
);

// File: tb/tb_gpio_sect_ctrl.sv
module tb_gpio_sect_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        write = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        ready;
  logic [15:0] rdata;
  logic [31:0] pins = '0;
  logic [31:0] gout, goe;
  logic        irq;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  gpio_sect_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(valid), .req_write_i(write), .req_addr_i(addr), .req_wdata_i(wdata),
    .req_ready_o(ready), .req_rdata_o(rdata),
    .gpio_i(pins), .gpio_o(gout), .gpio_oe_o(goe), .irq_o(irq)
  );

  function automatic logic [5:0] a(input int bank, input int ri);
    return {bank[1:0], ri[3:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] ad, input logic [15:0] d);
    @(negedge clk); valid = 1; write = 1; addr = ad; wdata = d;
    @(posedge clk); @(posedge clk);
    @(negedge clk); valid = 0; write = 0;
  endtask

  task automatic bus_rd(input logic [5:0] ad, output logic [15:0] d);
    @(negedge clk); valid = 1; write = 0; addr = ad;
    @(posedge clk);
    @(negedge clk); d = rdata;
    @(posedge clk);
    @(negedge clk); valid = 0;
  endtask

  task automatic expect_rd(input logic [5:0] ad, input logic [15:0] exp, input string req);
    logic [15:0] d;
    bus_rd(ad, d);
    check(d == exp, req, 32'(d), 32'(exp));
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    for (int k = 0; k < 4; k++) begin
      expect_rd(a(k, 4), 16'h00FF, "R1 dir");
      expect_rd(a(k, 2), 16'h00FF, "R1 mask");
      expect_rd(a(k, 8), 16'h0000, "R1 sticky");
      expect_rd(a(k, 5), 16'h0000, "R1 out");
    end
    check(goe == 0, "R1 oe", goe, 0);
    check(gout == 0, "R1 gpio_o", gout, 0);
    check(irq == 0, "R1 irq", 32'(irq), 0);
  endtask

  task automatic t_handshake;
    @(negedge clk); valid = 1; write = 0; addr = a(0, 4);
    check(ready == 0, "R10 ready before edge", 32'(ready), 0);
    @(posedge clk); @(negedge clk);
    check(ready == 1, "R10 ready after one edge", 32'(ready), 1);
    check(rdata == 16'h00FF, "R10 rdata with ready", 32'(rdata), 32'hFF);
    valid = 0;
    @(posedge clk); @(negedge clk);
    check(ready == 0, "R10 ready drops", 32'(ready), 0);
  endtask

  task automatic t_out_map;
    bus_wr(a(1, 4), 16'h00FB);
    check(goe == 32'h0000_0400, "R2 oe pin10", goe, 32'h400);
    bus_wr(a(1, 5), 16'hAB04);
    check(gout == 32'h0000_0400, "R2 out pin10", gout, 32'h400);
    expect_rd(a(1, 5), 16'h0004, "R9 upper bits");
    bus_wr(a(3, 5), 16'h0081);
    check(gout == 32'h8100_0400, "R2 out bank3", gout, 32'h81000400);
    bus_wr(a(1, 4), 16'h00FF);
    bus_wr(a(1, 5), 16'h0000);
    bus_wr(a(3, 5), 16'h0000);
    check(goe == 0 && gout == 0, "R2 restore", gout | goe, 0);
  endtask

  task automatic t_input;
    @(negedge clk); pins = 32'hA55A_3CC3;
    settle(3);
    expect_rd(a(0, 6), 16'h00C3, "R3 in bank0");
    expect_rd(a(1, 6), 16'h003C, "R3 in bank1");
    expect_rd(a(2, 6), 16'h005A, "R3 in bank2");
    expect_rd(a(3, 6), 16'h00A5, "R3 in bank3");
    bus_wr(a(2, 6), 16'h00FF);
    expect_rd(a(2, 6), 16'h005A, "R9 input write ignored");
    bus_wr(a(2, 0), 16'h00FF);
    expect_rd(a(2, 0), 16'h0000, "R9 mstat write ignored");
    @(negedge clk); pins = '0;
    settle(3);
  endtask

  task automatic t_mask;
    bus_wr(a(2, 3), 16'h000F);
    expect_rd(a(2, 2), 16'h00F0, "R6 unmask");
    bus_wr(a(2, 3), 16'h0000);
    expect_rd(a(2, 2), 16'h00F0, "R6 zero unmask no effect");
    bus_wr(a(2, 2), 16'h0001);
    expect_rd(a(2, 2), 16'h00F1, "R6 mask set");
    expect_rd(a(2, 3), 16'h0000, "R6 unmask reads 0");
    bus_wr(a(2, 2), 16'h00FF);
    expect_rd(a(2, 2), 16'h00FF, "R6 mask all");
  endtask

  task automatic t_level;
    bus_wr(a(0, 3), 16'h0008);
    check(irq == 0, "R7 irq idle", 32'(irq), 0);
    @(negedge clk); pins[3] = 1;
    @(posedge clk); @(negedge clk);
    check(irq == 0, "R3 one edge early", 32'(irq), 0);
    @(posedge clk); @(negedge clk);
    check(irq == 1, "R3 R4 second edge", 32'(irq), 1);
    expect_rd(a(0, 1), 16'h0008, "R4 raw high");
    expect_rd(a(0, 0), 16'h0008, "R7 masked high");
    @(negedge clk); pins[3] = 0;
    settle(3);
    expect_rd(a(0, 1), 16'h0000, "R4 raw follows low");
    check(irq == 0, "R4 irq low", 32'(irq), 0);
    bus_wr(a(0, 2), 16'h0008);
    @(negedge clk); pins[3] = 1;
    settle(3);
    expect_rd(a(0, 1), 16'h0008, "R7 raw when masked");
    expect_rd(a(0, 0), 16'h0000, "R7 masked hides");
    check(irq == 0, "R7 irq masked", 32'(irq), 0);
    @(negedge clk); pins[3] = 0;
    settle(3);
  endtask

  task automatic t_sticky;
    bus_wr(a(3, 8), 16'h0080);
    expect_rd(a(3, 8), 16'h0080, "R8 sticky set");
    bus_wr(a(3, 8), 16'h0000);
    expect_rd(a(3, 8), 16'h0080, "R8 zero write keeps");
    bus_wr(a(3, 3), 16'h0080);
    check(irq == 0, "R5 no event yet", 32'(irq), 0);
    @(negedge clk); pins[31] = 1;
    settle(2);
    pins[31] = 0;
    settle(4);
    expect_rd(a(3, 1), 16'h0080, "R5 latched after fall");
    check(irq == 1, "R5 R7 irq held", 32'(irq), 1);
    bus_wr(a(3, 1), 16'h0000);
    expect_rd(a(3, 1), 16'h0080, "R5 zero clear no effect");
    bus_wr(a(3, 1), 16'h0080);
    expect_rd(a(3, 1), 16'h0000, "R5 cleared");
    check(irq == 0, "R5 irq cleared", 32'(irq), 0);
    @(negedge clk); pins[31] = 1;
    settle(4);
    bus_wr(a(3, 1), 16'h0080);
    expect_rd(a(3, 1), 16'h0080, "R5 relatch while high");
    @(negedge clk); pins[31] = 0;
    settle(4);
    bus_wr(a(3, 1), 16'h0080);
    expect_rd(a(3, 1), 16'h0000, "R5 clear after low");
    expect_rd(a(3, 8), 16'h0080, "R8 still sticky");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_handshake();
    t_reset();
    t_out_map();
    t_input();
    t_mask();
    t_level();
    t_sticky();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule